// File: doc/BRIEF.md
# Wait-Request Bus Master Engine

This block sits between a local client and a memory-mapped bus whose slaves stretch transfers by holding a wait-request line high. The client presents a single read or write command with an address, byte-lane enables and, for writes, the data. The engine turns that command into one bus transfer and returns a one-cycle completion pulse. For a read, the returned data comes with the pulse.

The slave alone decides when a transfer ends. The engine raises its strobe together with the address and byte enables, and with the write data for a write. It then freezes every bus output for as long as the slave keeps wait-request high. The transfer completes on the first clock edge at which wait-request is sampled low. Only one transfer is in flight at a time. A busy flag tells the client when a new command would be ignored.

Top module: `wr_bus_master`

## Requirements
- R1: While reset is asserted and after it is released, bus_rd, bus_wr, busy and done are all 0.
- R2: A command is taken on a clock edge only when cmd_valid is 1 and busy is 0. A command presented while busy is 1 starts no transfer and changes no bus output.
- R3: On the cycle after a read command (cmd_write = 0) is taken, bus_rd is 1, bus_wr is 0, and bus_addr and bus_be equal the command's address and byte enables.
- R4: On the cycle after a write command (cmd_write = 1) is taken, bus_wr is 1, bus_rd is 0, and bus_addr, bus_be and bus_wdata equal the command's fields.
- R5: While a strobe is high and bus_wait is 1, bus_addr, bus_be, bus_wdata, bus_rd and bus_wr keep their values into the next cycle.
- R6: A read completes on the edge where bus_wait is sampled 0. The bus_rdata present at that edge appears on rdata in the following cycle.
- R7: bus_rd and bus_wr are never 1 together. Both are 0 in the cycle after the completing edge.
- R8: done is 1 for exactly one cycle per transfer: the cycle after the completing edge. In that cycle busy is 0.
- R9: busy is 1 from the cycle after a command is taken until the completing edge.
- R10: A write transfer leaves rdata unchanged; rdata holds the data of the last completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Client presents a command |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_addr | input | AW | Command address |
| cmd_be | input | DW/8 | Command byte-lane enables |
| cmd_wdata | input | DW | Command write data |
| busy | output | 1 | A transfer is in flight; commands are ignored |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Data of the last completed read |
| bus_addr | output | AW | Bus address |
| bus_be | output | DW/8 | Bus byte enables |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | DW | Bus write data |
| bus_wait | input | 1 | Slave stall request |
| bus_rdata | input | DW | Slave read data |

## Verification
The hardest case to reach from the ports is a client command that arrives in the middle of a long stall. If the engine took that command, it would overwrite the held address and strobes, and the slave would see a transfer that changes shape under it. The bench holds bus_wait high for several cycles on a read. During the stall it raises cmd_valid with a write to a different address. It then checks that bus_addr and the strobes keep the read's values and that no second transfer follows completion. The vector walk varies stall lengths from zero to seven cycles. It mixes partial byte enables against a slave memory model, so that each read returns data built from earlier merged writes.

// File: rtl/wr_bus_master.sv
module wr_bus_master #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [BW-1:0] cmd_be,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic [BW-1:0] bus_be,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_wait,
  input  logic [DW-1:0] bus_rdata
);

  logic          rd_q, wr_q, done_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] be_q;
  logic [DW-1:0] wdata_q, rdata_q;

  wire accept = cmd_valid && !busy;
  wire finish = (rd_q || wr_q) && !bus_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= finish;
      if (accept) begin
        rd_q    <= !cmd_write;
        wr_q    <= cmd_write;
        addr_q  <= cmd_addr;
        be_q    <= cmd_be;
        wdata_q <= cmd_wdata;
      end else if (finish) begin
        rd_q <= 1'b0;
        wr_q <= 1'b0;
      end
      if (finish && rd_q) rdata_q <= bus_rdata;
    end
  end

  assign busy      = rd_q || wr_q;
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign bus_addr  = addr_q;
  assign bus_be    = be_q;
  assign bus_rd    = rd_q;
  assign bus_wr    = wr_q;
  assign bus_wdata = wdata_q;

endmodule

// File: rtl/wr_bus_master_chk.sv
module wr_bus_master_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic [BW-1:0] cmd_be,
  input logic [DW-1:0] cmd_wdata,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic [AW-1:0] bus_addr,
  input logic [BW-1:0] bus_be,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_wait,
  input logic [DW-1:0] bus_rdata
);

  assert_excl_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_hold_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && bus_wait |=>
      $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata) &&
      $stable(bus_rd) && $stable(bus_wr));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && !bus_wait |=> !bus_rd && !bus_wr && done);

  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wait |=> rdata == $past(bus_rdata));

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) || $rose(bus_wr) |-> $past(cmd_valid) && !$past(busy));

  assert_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_wait |=> $stable(rdata));

endmodule

bind wr_bus_master wr_bus_master_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/wr_bus_master_bench.sv
module wr_bus_master_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int NV = 11;
  localparam int VW = 1 + AW + BW + DW + 4 + DW;

  // {write, addr, be, wdata, stall, expected read data}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 32'h00, 4'hF, 32'h11223344, 4'd0, 32'h0},
    {1'b0, 32'h00, 4'hF, 32'h0,        4'd2, 32'h11223344},
    {1'b1, 32'h04, 4'h3, 32'hAAAABBBB, 4'd3, 32'h0},
    {1'b0, 32'h04, 4'hF, 32'h0,        4'd0, 32'h0000BBBB},
    {1'b1, 32'h04, 4'hC, 32'h12345678, 4'd1, 32'h0},
    {1'b0, 32'h04, 4'hF, 32'h0,        4'd5, 32'h1234BBBB},
    {1'b1, 32'h08, 4'h1, 32'h000000EE, 4'd0, 32'h0},
    {1'b0, 32'h08, 4'hF, 32'h0,        4'd1, 32'h000000EE},
    {1'b1, 32'h0C, 4'h8, 32'hDE000000, 4'd7, 32'h0},
    {1'b0, 32'h0C, 4'hF, 32'h0,        4'd0, 32'hDE000000},
    {1'b0, 32'h00, 4'hF, 32'h0,        4'd4, 32'h11223344}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [BW-1:0] cmd_be = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          busy, done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] bus_addr;
  logic [BW-1:0] bus_be;
  logic          bus_rd, bus_wr;
  logic [DW-1:0] bus_wdata;
  logic          bus_wait = 1'b1;
  logic [DW-1:0] bus_rdata = '0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] mem [4];
  logic [DW-1:0] last_rd = '0;

  always #10 clk = ~clk;

  wr_bus_master #(.AW(AW), .DW(DW)) u_wr_bus_master (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input bit w, input logic [AW-1:0] a, input logic [BW-1:0] b,
                          input logic [DW-1:0] d, input int stall, input logic [DW-1:0] exp,
                          input bit intrude);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_be = b; cmd_wdata = d;
    bus_wait = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    if (w) chk(bus_wr && !bus_rd && bus_addr == a && bus_be == b && bus_wdata == d,
               "R4 write launch", {bus_wr, bus_rd, bus_addr}, {2'b10, a});
    else   chk(bus_rd && !bus_wr && bus_addr == a && bus_be == b,
               "R3 read launch", {bus_rd, bus_wr, bus_addr}, {2'b10, a});
    chk(busy, "R9 busy during transfer", busy, 1);
    for (int s = 0; s < stall; s++) begin
      if (intrude && s == 0) begin
        cmd_valid = 1'b1; cmd_write = ~w; cmd_addr = a + 32'h40; cmd_wdata = ~d;
      end
      @(posedge clk); @(negedge clk);
      cmd_valid = 1'b0;
      chk(bus_addr == a && bus_be == b && bus_rd == !w && bus_wr == w,
          intrude ? "R2 busy command ignored" : "R5 stable in stall",
          {bus_rd, bus_wr, bus_addr}, {!w, w, a});
    end
    bus_wait = 1'b0;
    bus_rdata = mem[a[3:2]];
    @(posedge clk); @(negedge clk);
    bus_wait = 1'b1;
    chk(done && !busy, "R8 done with busy low", {done, busy}, 2'b10);
    chk(!bus_rd && !bus_wr, "R7 strobes released", {bus_rd, bus_wr}, 0);
    if (!w) begin
      chk(rdata == exp, "R6 read data", rdata, exp);
      last_rd = exp;
    end else begin
      chk(rdata == last_rd, "R10 write keeps rdata", rdata, last_rd);
      for (int k = 0; k < BW; k++)
        if (b[k]) mem[a[3:2]][8*k +: 8] = d[8*k +: 8];
    end
    @(negedge clk);
    chk(!done, "R8 single-cycle done", done, 0);
    chk(!bus_rd && !bus_wr && !busy, "R2 no extra transfer", {bus_rd, bus_wr, busy}, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!bus_rd && !bus_wr && !busy && !done, "R1 in reset", {bus_rd, bus_wr, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !busy && !done, "R1 after reset", {bus_rd, bus_wr, busy, done}, 0);
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      run_xfer(e[VW-1], e[VW-2 -: AW], e[VW-2-AW -: BW], e[VW-2-AW-BW -: DW],
               int'(e[DW +: 4]), e[DW-1:0], 1'b0);
    end
    run_xfer(1'b0, 32'h04, 4'hF, 32'h0, 3, 32'h1234BBBB, 1'b1);
    run_xfer(1'b1, 32'h08, 4'h2, 32'h0000AB00, 2, 32'h0, 1'b1);
    run_xfer(1'b0, 32'h08, 4'hF, 32'h0, 0, 32'h0000ABEE, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule